// File: doc/BRIEF.md
# Cartridge Upload Size Detector with Address Mirroring

This block sits between a byte-wide loader write port and the CPU-side address path of an 8 KB cartridge window at 0xE000–0xFFFF. The loader pushes an image one byte per strobe, starting at the window base and stepping the address by one each time. The block never receives a size field. It infers the size of the image from which power-of-two boundaries inside the window the loader actually wrote to.

When the image is smaller than the window, the block repeats it across the whole window. It does this by forcing to zero the cartridge-relative address lines that the upload never reached, so no second copy of the data is stored. The top of the window, where the CPU fetches its reset vectors, therefore always holds valid image bytes. CPU addresses outside the window pass through untouched.

The loader strobe is a plain write pulse with no back-pressure: every strobe is accepted in the cycle it is high. Loader and CPU share one clock.

Top module: `cart_mirror`

## Requirements
- R1: After synchronous reset, `mirror_o` is 0, `size_o` is 0 (no detection), and every CPU address maps to itself.
- R2: One cycle after a loader write to exactly 0xE000, the block is armed and all reached flags are cleared. `size_o` reads 1 (2 KB image) and `mirror_o` reads 1. Inside the window, address bits 11 and 12 are forced to 0.
- R3: One cycle after an armed loader write to exactly 0xE800, `size_o` reads 2 (4 KB image) and `mirror_o` stays 1. Inside the window, bit 11 passes through and bit 12 is forced to 0.
- R4: One cycle after an armed loader write to exactly 0xF000, `size_o` reads 3 (8 KB image), `mirror_o` reads 0, and window addresses pass through unchanged.
- R5: Loader writes to any address other than 0xE000, 0xE800 and 0xF000 change nothing. Boundary writes made before any write to 0xE000 since reset are also ignored.
- R6: CPU addresses below 0xE000 always appear unchanged on `mem_addr_o`.
- R7: Detection state holds indefinitely while no loader write occurs. A new write to 0xE000 restarts detection from the 2 KB state.
- R8: A loader write changes the mapping only from the following cycle. In the write's own cycle, the previous mapping is still in force.
- R9: A larger boundary implies every smaller one. Reaching 0xF000 alone keeps both bits 11 and 12, even if 0xE800 was never written.
- R10: For an upload of L bytes from 0xE000, let the last offset be L-1. The detected size is 8 KB if the last offset is at least 0x1000, 4 KB if it is at least 0x800, and 2 KB otherwise. A window address at offset d maps to 0xE000 + (d mod size).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by loader and CPU side |
| rst | input | 1 | Synchronous active-high reset |
| ld_wr_i | input | 1 | Loader byte write strobe |
| ld_addr_i | input | 16 | Loader write address |
| cpu_addr_i | input | 16 | CPU address |
| mem_addr_o | output | 16 | Translated memory address (combinational from cpu_addr_i) |
| mirror_o | output | 1 | 1 when some window address line is being ignored |
| size_o | output | 2 | Detected size: 0 none, 1 = 2 KB, 2 = 4 KB, 3 = 8 KB |

## Verification
The bench uploads images whose lengths sit on either side of each boundary: 1, 0x7FF, 0x800, 0x801, 0xFFF, 0x1000, 0x1001 and 0x2000 bytes. After each upload it sweeps every window address against the modulo-size rule. A design that detected on "last address written" instead of boundary crossings, or that checked the wrong offset bit, would mirror a 0x801-byte image at 2 KB, or leave a 0x1000-byte image at 8 KB.

The bench also covers a write in the same cycle as a CPU access; a design with combinational detection would remap one cycle early. It also covers a lone write to 0xF000, where a design without the implied-lower-boundary rule would keep mirroring bit 11. Finally it checks stray and pre-arm boundary writes, which a careless design would let set flags.

// File: rtl/cart_mirror_pkg.sv
package cart_mirror_pkg;
  // Size code values reported on the status output.
  localparam int unsigned SZ_NONE = 0;
  localparam int unsigned SZ_MIN  = 1;
endpackage

// File: rtl/cm_detect.sv
module cm_detect #(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hE000,
  parameter int unsigned MIN_LOG2 = 11,
  parameter int unsigned NB       = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic              armed_o,
  output logic [NB-1:0]     reached_o
);
  logic          hit_base;
  logic [NB-1:0] hit_vec;

  assign hit_base = wr_i && (wr_addr_i == WIN_BASE);

  for (genvar k = 0; k < NB; k++) begin : g_bnd
    localparam logic [ADDR_W-1:0] BND = WIN_BASE + ADDR_W'(1 << (MIN_LOG2 + k));
    assign hit_vec[k] = wr_i && (wr_addr_i == BND);

    // R3
    bnd_set_chk: assert property (@(posedge clk) disable iff (rst)
      (armed_o && hit_vec[k] && !hit_base) |=> reached_o[k]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_o   <= 1'b0;
      reached_o <= '0;
    end else if (hit_base) begin
      armed_o   <= 1'b1;
      reached_o <= '0;
    end else if (armed_o) begin
      reached_o <= reached_o | hit_vec;
    end
  end

  // R2
  base_clear_chk: assert property (@(posedge clk) disable iff (rst)
    hit_base |=> (armed_o && reached_o == '0));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> ($stable(reached_o) && $stable(armed_o)));

  // R5
  unarmed_chk: assert property (@(posedge clk) disable iff (rst)
    (!armed_o && !hit_base) |=> (reached_o == '0));
endmodule

// File: rtl/cm_keep.sv
module cm_keep #(
  parameter int unsigned NB   = 2,
  parameter int unsigned SZ_W = 2
) (
  input  logic            armed_i,
  input  logic [NB-1:0]   reached_i,
  output logic [NB-1:0]   keep_o,
  output logic [SZ_W-1:0] size_o,
  output logic            mirror_o
);
  import cart_mirror_pkg::*;

  // A boundary counts as passed if it or any higher one was reached.
  always_comb begin
    for (int k = 0; k < NB; k++) begin
      keep_o[k] = !armed_i || (|(reached_i >> k));
    end
  end

  always_comb begin
    size_o = SZ_W'(SZ_MIN);
    for (int k = 0; k < NB; k++) begin
      if (reached_i[k]) size_o = SZ_W'(SZ_MIN + k + 1);
    end
    if (!armed_i) size_o = SZ_W'(SZ_NONE);
  end

  assign mirror_o = armed_i && !(&keep_o);
endmodule

// File: rtl/cm_xlate.sv
module cm_xlate #(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hE000,
  parameter int unsigned MIN_LOG2 = 11,
  parameter int unsigned MAX_LOG2 = 13
) (
  input  logic [ADDR_W-1:0]            cpu_addr_i,
  input  logic [MAX_LOG2-MIN_LOG2-1:0] keep_i,
  output logic [ADDR_W-1:0]            mem_addr_o
);
  localparam int unsigned NB = MAX_LOG2 - MIN_LOG2;

  logic in_win;
  assign in_win = (cpu_addr_i[ADDR_W-1:MAX_LOG2] == WIN_BASE[ADDR_W-1:MAX_LOG2]);

  always_comb begin
    mem_addr_o = cpu_addr_i;
    if (in_win) begin
      for (int k = 0; k < NB; k++) begin
        mem_addr_o[MIN_LOG2+k] = cpu_addr_i[MIN_LOG2+k] & keep_i[k];
      end
    end
  end
endmodule

// File: rtl/cart_mirror.sv
module cart_mirror #(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hE000,
  parameter int unsigned MIN_LOG2 = 11,
  parameter int unsigned MAX_LOG2 = 13,
  localparam int unsigned NB      = MAX_LOG2 - MIN_LOG2,
  localparam int unsigned SZ_W    = $clog2(NB + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_wr_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mirror_o,
  output logic [SZ_W-1:0]   size_o
);
  logic          armed;
  logic [NB-1:0] reached;
  logic [NB-1:0] keep;

  cm_detect #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .MIN_LOG2(MIN_LOG2), .NB(NB)) det_i (
    .clk(clk), .rst(rst), .wr_i(ld_wr_i), .wr_addr_i(ld_addr_i),
    .armed_o(armed), .reached_o(reached)
  );

  cm_keep #(.NB(NB), .SZ_W(SZ_W)) keep_i (
    .armed_i(armed), .reached_i(reached),
    .keep_o(keep), .size_o(size_o), .mirror_o(mirror_o)
  );

  cm_xlate #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2)) xl_i (
    .cpu_addr_i(cpu_addr_i), .keep_i(keep), .mem_addr_o(mem_addr_o)
  );

  // R6
  outside_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr_i < WIN_BASE) |-> (mem_addr_o == cpu_addr_i));

  // R4
  full_image_chk: assert property (@(posedge clk) disable iff (rst)
    (size_o == SZ_W'(NB + 1)) |-> (!mirror_o && mem_addr_o == cpu_addr_i));

  // R9
  top_implies_all_chk: assert property (@(posedge clk) disable iff (rst)
    reached[NB-1] |-> (&keep));

  // R1
  unarmed_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (size_o == '0) |-> (!mirror_o && mem_addr_o == cpu_addr_i));
endmodule

// File: tb/cart_mirror_tb_top.sv
module cart_mirror_tb_top;
  localparam int CLK_P = 10;
  localparam logic [15:0] BASE = 16'hE000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_wr_i = 1'b0;
  logic [15:0] ld_addr_i = '0;
  logic [15:0] cpu_addr_i = '0;
  logic [15:0] mem_addr_o;
  logic        mirror_o;
  logic [1:0]  size_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  cart_mirror dut_i (
    .clk(clk), .rst(rst), .ld_wr_i(ld_wr_i), .ld_addr_i(ld_addr_i),
    .cpu_addr_i(cpu_addr_i), .mem_addr_o(mem_addr_o),
    .mirror_o(mirror_o), .size_o(size_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic ld_write(input logic [15:0] a);
    @(negedge clk);
    ld_wr_i = 1'b1;
    ld_addr_i = a;
    @(negedge clk);
    ld_wr_i = 1'b0;
  endtask

  task automatic upload(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      ld_wr_i = 1'b1;
      ld_addr_i = BASE + 16'(i);
    end
    @(negedge clk);
    ld_wr_i = 1'b0;
  endtask

  // Sweep the whole window: offset d maps to BASE + (d mod size_bytes).
  task automatic sweep(input int size_bytes, input string req);
    for (int d = 0; d < 8192; d++) begin
      cpu_addr_i = BASE + 16'(d);
      #1;
      chk(mem_addr_o == BASE + 16'(d % size_bytes), req, mem_addr_o, BASE + (d % size_bytes));
    end
  endtask

  task automatic outside(input string req);
    for (int a = 0; a < 16'hE000; a += 16'h0137) begin
      cpu_addr_i = 16'(a);
      #1;
      chk(mem_addr_o == 16'(a), req, mem_addr_o, a);
    end
  endtask

  function automatic int exp_code(input int len);
    int last = len - 1;
    if (last >= 16'h1000) return 3;
    if (last >= 16'h0800) return 2;
    return 1;
  endfunction

  initial begin
    #(CLK_P * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lens[8] = '{1, 16'h7FF, 16'h800, 16'h801, 16'hFFF, 16'h1000, 16'h1001, 16'h2000};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(size_o == 2'd0, "R1 size", size_o, 0);
    chk(mirror_o == 1'b0, "R1 mirror", mirror_o, 0);
    sweep(8192, "R1 identity");

    // R5 boundary writes before arming are ignored
    ld_write(16'hE800);
    ld_write(16'hF000);
    ld_write(16'hE000);
    chk(size_o == 2'd1, "R5 pre-arm ignored", size_o, 1);
    chk(mirror_o == 1'b1, "R2 mirror on", mirror_o, 1);
    sweep(2048, "R2 2K map");

    // R5 stray writes after arming
    ld_write(16'hE801);
    ld_write(16'h1234);
    ld_write(16'hEFFF);
    chk(size_o == 2'd1, "R5 stray writes", size_o, 1);

    // R10 size sweep over upload lengths (R2 R3 R4)
    foreach (lens[i]) begin
      int c;
      upload(lens[i]);
      c = exp_code(lens[i]);
      chk(size_o == 2'(c), "R10 size code", size_o, c);
      chk(mirror_o == (c != 3), "R10 mirror flag", mirror_o, c != 3);
      sweep(2048 << (c - 1), "R10 window map");
    end
    outside("R6 outside pass");

    // R7 hold across idle, then restart
    repeat (20) @(negedge clk);
    chk(size_o == 2'd3, "R7 hold", size_o, 3);
    ld_write(BASE);
    chk(size_o == 2'd1, "R7 restart", size_o, 1);

    // R8 write takes effect next cycle
    @(negedge clk);
    ld_wr_i = 1'b1;
    ld_addr_i = 16'hE800;
    cpu_addr_i = 16'hE800;
    #1;
    chk(mem_addr_o == 16'hE000, "R8 same cycle old map", mem_addr_o, 16'hE000);
    @(negedge clk);
    ld_wr_i = 1'b0;
    #1;
    chk(mem_addr_o == 16'hE800, "R8 next cycle new map", mem_addr_o, 16'hE800);
    chk(size_o == 2'd2, "R3 size 4K", size_o, 2);
    sweep(4096, "R3 4K map");

    // R9 top boundary alone implies full
    ld_write(BASE);
    ld_write(16'hF000);
    chk(size_o == 2'd3, "R9 size", size_o, 3);
    chk(mirror_o == 1'b0, "R9 mirror off", mirror_o, 0);
    sweep(8192, "R9 identity");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule